// File: doc/BRIEF.md
# Address-Unit Pipeline Hazard Checker

This block watches the stream of execution sets that leave the decoder, one set per clock cycle. It flags any set whose use of address-unit registers breaks the pipeline timing rules. Each set has a set-level valid bit and a delay-slot flag, plus `NSLOT` descriptor slots. Each slot gives an operation class, at most one written register and at most one read register. A read is marked either as a pointer/operand use or as a move source. The checker keeps a short history of recent writes. It applies latency rules across cycles and grouping rules within a set. For every set that breaks a rule it emits a one-cycle report with a rule code, the offending slot and the set's cycle number.

The input side follows stream conventions, but `set_ready` is held high: the checker never applies back-pressure. The producer may present a set on every cycle. A cycle with `set_valid` low is a bubble. A bubble adds no reads and no writes, but it still counts as an elapsed cycle for every latency window. The report output is a plain pulse with no handshake. The report for the set seen in cycle N appears one clock later, with `viol_cycle` = N.

Operation class codes: 0 no-op, 1 address arithmetic (modifier-mode sensitive), 2 move-like (move, pop, bit-mask), 3 jump through register, 4 loop start, 5 conditional jump (true or false), 6 trap, 7 other change of flow, 8 continue/break/skip, 9 stop/wait, 10 interrupt disable, 11 other. Register codes: 0–15 R0–R15, 16–23 N0–N7, 24–31 M0–M7, 32–39 B0–B7, 40 modulo control, 44–47 loop counters LC0–LC3.

Top module: `agu_hazard_chk`

## Requirements
- R1: If a live slot writes register 40 (modulo control) in cycle t, then a class-1 slot in cycle t+1 or t+2 that reads register 0–7 as pointer/operand (`rd_src`=0) gives rule code 1. The same read in t+3, or a read of register 8 or above, gives no rule-1 report.
- R2: If a class-2 slot writes register 0–39 in cycle t, then a slot in cycle t+1 that reads the same register as pointer/operand gives rule code 2. A read marked as move source (`rd_src`=1), or a read in t+2, does not.
- R3: Register codes 8+k and 32+k (k = 0..7) name the same physical register for rules 2 and 4.
- R4: A class-3 or class-4 slot that reads a register as pointer/operand is treated as a read under R2.
- R5: After a set that holds a live class-5 or class-6 slot, the next cycle gives rule code 3 with slot 0 if it is a bubble or has no valid slot. A set holding only a class-0 slot is accepted.
- R6: Within one set, a class-1 slot that writes a register, together with a class-2 slot that reads the same physical register (either role), gives rule code 4 at the reading slot. A non-move reader gives no report.
- R7: Within one set, a class-4 slot that writes loop counter 44–47, together with a class-2 slot that reads that same counter, gives rule code 5 at the reading slot. A different counter gives no report.
- R8: A valid set with `set_delay` high that holds a live slot of class 3, 5, 6, 7, 8, 9 or 10 gives rule code 6. The same classes with `set_delay` low give no report.
- R9: When several violations hit in one set, the lowest rule code is reported. Within that code, the lowest slot index is reported.
- R10: A report appears one cycle after its set, and `viol_cycle` equals the number of cycles since reset was released, counting from 0.
- R11: Synchronous reset clears all history and the output. A hazard source seen before reset causes no report after it.
- R12: `set_ready` is always high. Slot fields of a bubble are ignored, including delay-slot and branch content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_valid | input | 1 | Execution set present this cycle |
| set_ready | output | 1 | Always 1; no back-pressure |
| set_delay | input | 1 | Set occupies a delay slot |
| slot_vld | input | NSLOT | Per-slot descriptor valid |
| slot_op | input | NSLOT x 4 | Per-slot operation class |
| slot_wr_en | input | NSLOT | Slot writes a register |
| slot_wr_reg | input | NSLOT x 6 | Written register code |
| slot_rd_en | input | NSLOT | Slot reads a register |
| slot_rd_reg | input | NSLOT x 6 | Read register code |
| slot_rd_src | input | NSLOT | 1 = read as move source, 0 = pointer/operand |
| viol_valid | output | 1 | Violation report pulse |
| viol_rule | output | 3 | Rule code 1..6 |
| viol_slot | output | log2(NSLOT) | Offending slot index |
| viol_cycle | output | CYC_W | Cycle number of the offending set |

## Verification
The modulo-control window and the move-latency window can both hit the same read in one cycle. The delay-slot ban can hit that same set as well. The bench provokes this with one set that writes modulo control and moves into R3. The next set is marked as a delay slot, reads R3 through address arithmetic and holds an interrupt disable. The report must carry rule 1 at the arithmetic slot. The following set, still inside the modulo window, combines a same-set grouping hazard with a delay-slot ban. It is judged the same way: the lower code must win, at the lowest offending slot.

// File: rtl/agu_hz_pkg.sv
package agu_hz_pkg;
  localparam int OP_W   = 4;
  localparam int REG_W  = 6;
  localparam int RULE_W = 3;
  localparam int PHYS_N = 32;
  localparam int LC_N   = 4;
  localparam int NRULE  = 6;

  localparam logic [OP_W-1:0] OP_NOP    = 4'd0;
  localparam logic [OP_W-1:0] OP_ARITH  = 4'd1;
  localparam logic [OP_W-1:0] OP_MOVE   = 4'd2;
  localparam logic [OP_W-1:0] OP_JMPR   = 4'd3;
  localparam logic [OP_W-1:0] OP_LOOP   = 4'd4;
  localparam logic [OP_W-1:0] OP_CJMP   = 4'd5;
  localparam logic [OP_W-1:0] OP_TRAP   = 4'd6;
  localparam logic [OP_W-1:0] OP_COF    = 4'd7;
  localparam logic [OP_W-1:0] OP_FLOW   = 4'd8;
  localparam logic [OP_W-1:0] OP_LOWPWR = 4'd9;
  localparam logic [OP_W-1:0] OP_DI     = 4'd10;

  localparam logic [REG_W-1:0] REG_MCTL = 6'd40;

  // physical register one-hot; upper pointers and base registers share 8..15
  function automatic logic [PHYS_N-1:0] phys_bit(input logic [REG_W-1:0] c);
    logic [PHYS_N-1:0] m;
    m = '0;
    if (c < 6'd32)      m[c[4:0]] = 1'b1;
    else if (c < 6'd40) m[{2'b01, c[2:0]}] = 1'b1;
    return m;
  endfunction

  function automatic logic is_lc(input logic [REG_W-1:0] c);
    return c[5:2] == 4'b1011;
  endfunction

  function automatic logic [LC_N-1:0] lc_bit(input logic [REG_W-1:0] c);
    logic [LC_N-1:0] m;
    m = '0;
    if (is_lc(c)) m[c[1:0]] = 1'b1;
    return m;
  endfunction

  function automatic logic dslot_banned(input logic [OP_W-1:0] op);
    return (op == OP_JMPR) || (op == OP_CJMP) || (op == OP_TRAP) || (op == OP_COF) ||
           (op == OP_FLOW) || (op == OP_LOWPWR) || (op == OP_DI);
  endfunction
endpackage

// File: rtl/agu_hz_hist.sv
module agu_hz_hist import agu_hz_pkg::*; #(
  parameter int GAP = 2
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              mctl_now,
  input  logic [PHYS_N-1:0] move_now,
  input  logic              cj_now,
  output logic              mctl_recent,
  output logic [PHYS_N-1:0] move_prev,
  output logic              cj_prev
);
  logic [GAP-1:0] mctl_sh;

  generate
    if (GAP == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) mctl_sh <= '0;
        else     mctl_sh <= mctl_now;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) mctl_sh <= '0;
        else     mctl_sh <= {mctl_sh[GAP-2:0], mctl_now};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      move_prev <= '0;
      cj_prev   <= 1'b0;
    end else begin
      move_prev <= move_now;
      cj_prev   <= cj_now;
    end
  end

  assign mctl_recent = |mctl_sh;
endmodule

// File: rtl/agu_hz_slot.sv
module agu_hz_slot import agu_hz_pkg::*; (
  input  logic              live,
  input  logic              set_delay,
  input  logic [OP_W-1:0]   op,
  input  logic              rd_en,
  input  logic [REG_W-1:0]  rd_reg,
  input  logic              rd_src,
  input  logic              mctl_recent,
  input  logic [PHYS_N-1:0] move_prev,
  input  logic [PHYS_N-1:0] arith_set,
  input  logic [LC_N-1:0]   lc_set,
  output logic              f_mod,
  output logic              f_lat,
  output logic              f_grp,
  output logic              f_lc,
  output logic              f_dly
);
  logic [PHYS_N-1:0] rd_bit;
  logic              ptr_rd;

  assign rd_bit = phys_bit(rd_reg);
  assign ptr_rd = live & rd_en & ~rd_src;

  assign f_mod = ptr_rd & (op == OP_ARITH) & (rd_reg < 6'd8) & mctl_recent;
  assign f_lat = ptr_rd & (|(rd_bit & move_prev));
  assign f_grp = live & rd_en & (op == OP_MOVE) & (|(rd_bit & arith_set));
  assign f_lc  = live & rd_en & (op == OP_MOVE) & (|(lc_bit(rd_reg) & lc_set));
  assign f_dly = live & set_delay & dslot_banned(op);
endmodule

// File: rtl/agu_hz_arb.sv
module agu_hz_arb import agu_hz_pkg::*; #(
  parameter int NSLOT  = 4,
  parameter int SLOT_W = 2
)(
  input  logic [NSLOT-1:0][NRULE-1:0] flags,
  output logic                        hit,
  output logic [RULE_W-1:0]           rule,
  output logic [SLOT_W-1:0]           slot
);
  // descending scan: the last match is the lowest rule, then the lowest slot
  always_comb begin
    hit  = 1'b0;
    rule = '0;
    slot = '0;
    for (int r = NRULE - 1; r >= 0; r--) begin
      for (int s = NSLOT - 1; s >= 0; s--) begin
        if (flags[s][r]) begin
          hit  = 1'b1;
          rule = RULE_W'(r + 1);
          slot = SLOT_W'(s);
        end
      end
    end
  end
endmodule

// File: rtl/agu_hazard_chk.sv
module agu_hazard_chk import agu_hz_pkg::*; #(
  parameter int NSLOT    = 4,
  parameter int CYC_W    = 16,
  parameter int MCTL_GAP = 2,
  localparam int SLOT_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1
)(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         set_valid,
  output logic                         set_ready,
  input  logic                         set_delay,
  input  logic [NSLOT-1:0]             slot_vld,
  input  logic [NSLOT-1:0][OP_W-1:0]   slot_op,
  input  logic [NSLOT-1:0]             slot_wr_en,
  input  logic [NSLOT-1:0][REG_W-1:0]  slot_wr_reg,
  input  logic [NSLOT-1:0]             slot_rd_en,
  input  logic [NSLOT-1:0][REG_W-1:0]  slot_rd_reg,
  input  logic [NSLOT-1:0]             slot_rd_src,
  output logic                         viol_valid,
  output logic [RULE_W-1:0]            viol_rule,
  output logic [SLOT_W-1:0]            viol_slot,
  output logic [CYC_W-1:0]             viol_cycle
);
  logic [NSLOT-1:0]              live, c_mctl, c_cj;
  logic [NSLOT-1:0][PHYS_N-1:0]  c_move, c_arith;
  logic [NSLOT-1:0][LC_N-1:0]    c_lc;
  logic [NSLOT-1:0]              f_mod, f_lat, f_grp, f_lc, f_dly;
  logic [NSLOT-1:0][NRULE-1:0]   flags;

  logic              mctl_now, cj_now, mctl_recent, cj_prev, r3_hit;
  logic [PHYS_N-1:0] move_now, arith_set, move_prev;
  logic [LC_N-1:0]   lc_set;

  logic              hit;
  logic [RULE_W-1:0] hit_rule;
  logic [SLOT_W-1:0] hit_slot;
  logic [CYC_W-1:0]  cyc_q;

  assign set_ready = 1'b1;

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign live[s]    = set_valid & slot_vld[s];
      assign c_mctl[s]  = live[s] & slot_wr_en[s] & (slot_wr_reg[s] == REG_MCTL);
      assign c_move[s]  = (live[s] & slot_wr_en[s] & (slot_op[s] == OP_MOVE))
                          ? phys_bit(slot_wr_reg[s]) : '0;
      assign c_arith[s] = (live[s] & slot_wr_en[s] & (slot_op[s] == OP_ARITH))
                          ? phys_bit(slot_wr_reg[s]) : '0;
      assign c_lc[s]    = (live[s] & slot_wr_en[s] & (slot_op[s] == OP_LOOP))
                          ? lc_bit(slot_wr_reg[s]) : '0;
      assign c_cj[s]    = live[s] & ((slot_op[s] == OP_CJMP) | (slot_op[s] == OP_TRAP));

      agu_hz_slot u_slot (
        .live        (live[s]),
        .set_delay   (set_delay),
        .op          (slot_op[s]),
        .rd_en       (slot_rd_en[s]),
        .rd_reg      (slot_rd_reg[s]),
        .rd_src      (slot_rd_src[s]),
        .mctl_recent (mctl_recent),
        .move_prev   (move_prev),
        .arith_set   (arith_set),
        .lc_set      (lc_set),
        .f_mod       (f_mod[s]),
        .f_lat       (f_lat[s]),
        .f_grp       (f_grp[s]),
        .f_lc        (f_lc[s]),
        .f_dly       (f_dly[s])
      );

      if (s == 0) begin : g_r3
        assign flags[s] = {f_dly[s], f_lc[s], f_grp[s], r3_hit, f_lat[s], f_mod[s]};
      end else begin : g_nr3
        assign flags[s] = {f_dly[s], f_lc[s], f_grp[s], 1'b0, f_lat[s], f_mod[s]};
      end
    end
  endgenerate

  always_comb begin
    move_now  = '0;
    arith_set = '0;
    lc_set    = '0;
    for (int s = 0; s < NSLOT; s++) begin
      move_now  = move_now | c_move[s];
      arith_set = arith_set | c_arith[s];
      lc_set    = lc_set | c_lc[s];
    end
  end

  assign mctl_now = |c_mctl;
  assign cj_now   = |c_cj;
  assign r3_hit   = cj_prev & ~(|live);

  agu_hz_hist #(.GAP(MCTL_GAP)) u_hist (
    .clk         (clk),
    .rst         (rst),
    .mctl_now    (mctl_now),
    .move_now    (move_now),
    .cj_now      (cj_now),
    .mctl_recent (mctl_recent),
    .move_prev   (move_prev),
    .cj_prev     (cj_prev)
  );

  agu_hz_arb #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_arb (
    .flags (flags),
    .hit   (hit),
    .rule  (hit_rule),
    .slot  (hit_slot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q      <= '0;
      viol_valid <= 1'b0;
      viol_rule  <= '0;
      viol_slot  <= '0;
      viol_cycle <= '0;
    end else begin
      cyc_q      <= cyc_q + 1'b1;
      viol_valid <= hit;
      viol_rule  <= hit_rule;
      viol_slot  <= hit_slot;
      viol_cycle <= cyc_q;
    end
  end
endmodule

// File: rtl/agu_hz_sva.sv
module agu_hz_sva import agu_hz_pkg::*; #(
  parameter int NSLOT = 4,
  parameter int CYC_W = 16
)(
  input logic                       clk,
  input logic                       rst,
  input logic                       set_valid,
  input logic                       set_delay,
  input logic [NSLOT-1:0]           slot_vld,
  input logic [NSLOT-1:0][OP_W-1:0] slot_op,
  input logic                       viol_valid,
  input logic [RULE_W-1:0]          viol_rule,
  input logic [CYC_W-1:0]           viol_cycle
);
  logic branch_now, banned_now, branch_q;

  always_comb begin
    branch_now = 1'b0;
    banned_now = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      if (set_valid && slot_vld[s]) begin
        if (slot_op[s] == OP_CJMP || slot_op[s] == OP_TRAP) branch_now = 1'b1;
        if (set_delay && dslot_banned(slot_op[s]))           banned_now = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) branch_q <= 1'b0;
    else     branch_q <= branch_now;
  end

  a_r5_bubble_after_branch: assert property (@(posedge clk) disable iff (rst)
    branch_q && !set_valid |=> viol_valid && viol_rule == 3'd3);

  a_r8_delay_banned: assert property (@(posedge clk) disable iff (rst)
    banned_now |=> viol_valid);

  a_r9_rule_range: assert property (@(posedge clk) disable iff (rst)
    viol_valid |-> (viol_rule >= 3'd1 && viol_rule <= 3'd6));

  a_r10_cycle_step: assert property (@(posedge clk) disable iff (rst)
    viol_valid && $past(viol_valid) |-> viol_cycle == CYC_W'($past(viol_cycle) + 1'b1));

  a_r11_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !viol_valid);

  a_r12_bubble_quiet: assert property (@(posedge clk) disable iff (rst)
    !set_valid && !branch_q |=> !viol_valid);
endmodule

bind agu_hazard_chk agu_hz_sva #(.NSLOT(NSLOT), .CYC_W(CYC_W)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .set_valid  (set_valid),
  .set_delay  (set_delay),
  .slot_vld   (slot_vld),
  .slot_op    (slot_op),
  .viol_valid (viol_valid),
  .viol_rule  (viol_rule),
  .viol_cycle (viol_cycle)
);

// File: tb/test_agu_hazard_chk.sv
`timescale 1ns/1ps
module test_agu_hazard_chk;
  localparam int NS = 4;
  localparam logic [3:0] NOP = 0, ARI = 1, MOV = 2, JMR = 3, LOP = 4, CJ = 5,
                         TRP = 6, COF = 7, FLW = 8, LPW = 9, DI = 10, OTH = 11;
  localparam logic [5:0] MCTL = 6'd40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic set_valid, set_ready, set_delay;
  logic [NS-1:0] b_vld, b_wr_en, b_rd_en, b_rd_src;
  logic [NS-1:0][3:0] b_op;
  logic [NS-1:0][5:0] b_wr_reg, b_rd_reg;
  logic viol_valid;
  logic [2:0] viol_rule;
  logic [1:0] viol_slot;
  logic [15:0] viol_cycle;

  int checks = 0;
  int errors = 0;
  int bcyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] rule;
    logic [1:0] slot;
    int cyc;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  agu_hazard_chk i_agu_hazard_chk (
    .clk(clk), .rst(rst), .set_valid(set_valid), .set_ready(set_ready),
    .set_delay(set_delay), .slot_vld(b_vld), .slot_op(b_op),
    .slot_wr_en(b_wr_en), .slot_wr_reg(b_wr_reg), .slot_rd_en(b_rd_en),
    .slot_rd_reg(b_rd_reg), .slot_rd_src(b_rd_src),
    .viol_valid(viol_valid), .viol_rule(viol_rule), .viol_slot(viol_slot),
    .viol_cycle(viol_cycle)
  );

  task automatic clr();
    set_valid = 1'b1; set_delay = 1'b0;
    b_vld = '0; b_op = '0; b_wr_en = '0; b_wr_reg = '0;
    b_rd_en = '0; b_rd_reg = '0; b_rd_src = '0;
  endtask

  task automatic put(int s, logic [3:0] op, logic we, logic [5:0] wr,
                     logic re, logic [5:0] rr, logic src);
    b_vld[s] = 1'b1; b_op[s] = op; b_wr_en[s] = we; b_wr_reg[s] = wr;
    b_rd_en[s] = re; b_rd_reg[s] = rr; b_rd_src[s] = src;
  endtask

  // driver: queue the expectation for the presented set, then advance one cycle
  task automatic step(logic [2:0] rule, logic [1:0] slot, string tag);
    exp_t e;
    e.rule = rule; e.slot = slot; e.cyc = bcyc; e.tag = tag;
    sb.push_back(e);
    bcyc++;
    @(posedge clk);
    @(negedge clk);
    clr();
  endtask

  // monitor: one expectation per set, output sampled 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (e.rule == 3'd0) begin
          if (viol_valid) begin
            errors++;
            $display("FAIL %s: got valid=1 rule=%0d slot=%0d, expected no report",
                     e.tag, viol_rule, viol_slot);
          end
        end else if (!viol_valid || viol_rule != e.rule || viol_slot != e.slot ||
                     viol_cycle != 16'(e.cyc)) begin
          errors++;
          $display("FAIL %s: got valid=%0b rule=%0d slot=%0d cyc=%0d, expected rule=%0d slot=%0d cyc=%0d",
                   e.tag, viol_valid, viol_rule, viol_slot, viol_cycle, e.rule, e.slot, e.cyc);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clr();
    set_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (viol_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset state: got valid=%0b, expected 0", viol_valid);
    end
    @(negedge clk);
    rst = 1'b0;
    clr();

    put(0, NOP, 0, 0, 0, 0, 0); step(0, 0, "R10 clean set");

    // R1 modulo-control window
    put(0, OTH, 1, MCTL, 0, 0, 0); step(0, 0, "R1 mctl write");
    put(1, ARI, 0, 0, 1, 6'd3, 0); step(1, 1, "R1 first set after");
    put(0, ARI, 0, 0, 1, 6'd7, 0); step(1, 0, "R1 second set after");
    put(2, ARI, 0, 0, 1, 6'd0, 0); step(0, 0, "R1 third set clean");
    put(0, OTH, 1, MCTL, 0, 0, 0); step(0, 0, "R1 mctl write");
    put(0, ARI, 0, 0, 1, 6'd8, 0); step(0, 0, "R1 R8 outside range");
    set_valid = 1'b0;              step(0, 0, "R12 bubble in window");
    put(0, ARI, 0, 0, 1, 6'd0, 0); step(0, 0, "R1 third cycle clean");
    put(0, OTH, 1, MCTL, 0, 0, 0); step(0, 0, "R1 mctl write");
    set_valid = 1'b0;              step(0, 0, "R12 bubble counts");
    put(0, ARI, 0, 0, 1, 6'd2, 0); step(1, 0, "R1 after bubble");

    // R2 move latency
    put(0, MOV, 1, 6'd19, 0, 0, 0); step(0, 0, "R2 move N3");
    put(3, ARI, 0, 0, 1, 6'd19, 0); step(2, 3, "R2 pointer read");
    put(0, MOV, 1, 6'd25, 0, 0, 0); step(0, 0, "R2 move M1");
    put(1, MOV, 0, 0, 1, 6'd25, 1); step(0, 0, "R2 source read ignored");
    put(0, MOV, 1, 6'd5, 0, 0, 0);  step(0, 0, "R2 move R5");
    set_valid = 1'b0;               step(0, 0, "R2 bubble");
    put(0, ARI, 0, 0, 1, 6'd5, 0);  step(0, 0, "R2 two cycles later");

    // R3 aliasing
    put(0, MOV, 1, 6'd32, 0, 0, 0); step(0, 0, "R3 move B0");
    put(0, OTH, 0, 0, 1, 6'd8, 0);  step(2, 0, "R3 read R8 after B0");
    put(0, MOV, 1, 6'd12, 0, 0, 0); step(0, 0, "R3 move R12");
    put(2, OTH, 0, 0, 1, 6'd36, 0); step(2, 2, "R3 read B4 after R12");
    put(0, MOV, 1, 6'd4, 0, 0, 0);  step(0, 0, "R3 move R4");
    put(0, OTH, 0, 0, 1, 6'd36, 0); step(0, 0, "R3 B4 not R4");

    // R4 jump and loop-start reads
    put(0, MOV, 1, 6'd6, 0, 0, 0);  step(0, 0, "R4 move R6");
    put(0, JMR, 0, 0, 1, 6'd6, 0);  step(2, 0, "R4 jump through R6");
    put(0, MOV, 1, 6'd1, 0, 0, 0);  step(0, 0, "R4 move R1");
    put(1, LOP, 1, 6'd44, 1, 6'd1, 0); step(2, 1, "R4 loop start from R1");

    // R5 slot after conditional jump / trap
    put(2, CJ, 0, 0, 0, 0, 0);      step(0, 0, "R5 cond jump");
    set_valid = 1'b0;               step(3, 0, "R5 bubble after jump");
    put(0, TRP, 0, 0, 0, 0, 0);     step(0, 0, "R5 trap");
    step(3, 0, "R5 empty set after trap");
    put(1, CJ, 0, 0, 0, 0, 0);      step(0, 0, "R5 cond jump");
    put(0, NOP, 0, 0, 0, 0, 0);     step(0, 0, "R5 no-op accepted");

    // R6 same-set arithmetic / move grouping
    put(0, ARI, 1, 6'd2, 0, 0, 0); put(1, MOV, 0, 0, 1, 6'd2, 1);
    step(4, 1, "R6 arith+move source");
    put(0, ARI, 1, 6'd33, 0, 0, 0); put(3, MOV, 0, 0, 1, 6'd9, 0);
    step(4, 3, "R6 aliased grouping");
    put(0, ARI, 1, 6'd2, 0, 0, 0); put(1, ARI, 0, 0, 1, 6'd2, 0);
    step(0, 0, "R6 non-move reader");

    // R7 loop counter grouping
    put(0, LOP, 1, 6'd45, 0, 0, 0); put(2, MOV, 0, 0, 1, 6'd45, 1);
    step(5, 2, "R7 same counter");
    put(0, LOP, 1, 6'd45, 0, 0, 0); put(2, MOV, 0, 0, 1, 6'd46, 1);
    step(0, 0, "R7 other counter");

    // R8 delay-slot bans
    set_delay = 1'b1; put(1, COF, 0, 0, 0, 0, 0); step(6, 1, "R8 change of flow");
    set_delay = 1'b1; put(3, DI, 0, 0, 0, 0, 0);  step(6, 3, "R8 interrupt disable");
    set_delay = 1'b1; put(0, NOP, 0, 0, 0, 0, 0); put(1, ARI, 0, 0, 0, 0, 0);
    put(2, MOV, 0, 0, 0, 0, 0);                   step(0, 0, "R8 allowed classes");
    put(0, COF, 0, 0, 0, 0, 0);                   step(0, 0, "R8 not delay slot");
    set_delay = 1'b1; put(0, LPW, 0, 0, 0, 0, 0); step(6, 0, "R8 low power");
    set_delay = 1'b1; put(2, FLW, 0, 0, 0, 0, 0); step(6, 2, "R8 break/skip");

    // R9 priority
    put(0, OTH, 1, MCTL, 0, 0, 0); put(1, MOV, 1, 6'd3, 0, 0, 0);
    step(0, 0, "R9 setup");
    set_delay = 1'b1; put(0, DI, 0, 0, 0, 0, 0); put(3, ARI, 0, 0, 1, 6'd3, 0);
    step(1, 3, "R9 rule1 beats 2 and 6");
    set_delay = 1'b1; put(1, COF, 0, 0, 0, 0, 0); put(2, ARI, 1, 6'd4, 0, 0, 0);
    put(3, MOV, 0, 0, 1, 6'd4, 1);
    step(4, 3, "R9 rule4 beats 6");
    set_delay = 1'b1; put(1, COF, 0, 0, 0, 0, 0); put(3, COF, 0, 0, 0, 0, 0);
    step(6, 1, "R9 lowest slot");

    // R12 bubble content ignored
    set_delay = 1'b1; put(0, COF, 0, 0, 0, 0, 0); put(1, CJ, 0, 0, 0, 0, 0);
    set_valid = 1'b0; step(0, 0, "R12 bubble with banned ops");
    set_valid = 1'b0; step(0, 0, "R12 no rule3 after bubble");
    checks++;
    if (set_ready !== 1'b1) begin
      errors++;
      $display("FAIL R12 ready: got %0b, expected 1", set_ready);
    end

    // R11 reset clears history, R10 counter restarts
    put(0, OTH, 1, MCTL, 0, 0, 0); put(1, MOV, 1, 6'd0, 0, 0, 0);
    step(0, 0, "R11 hazards before reset");
    rst = 1'b1; set_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; bcyc = 0; clr();
    put(0, ARI, 0, 0, 1, 6'd0, 0); step(0, 0, "R11 no stale hazard");
    put(0, MOV, 1, 6'd20, 0, 0, 0); step(0, 0, "R10 move N4");
    put(1, ARI, 0, 0, 1, 6'd20, 0); step(2, 1, "R10 cycle restarts");

    set_valid = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule